// File: doc/BRIEF.md
# GPIO Bank with Interrupt Sensing

This block is a bank of 32 general-purpose pins behind a small word-addressed register file. Each pin is either an input or a driven output, chosen by a direction bit. Software writes output levels through the data register and reads back the state of every pin there: the driven level for outputs and the synchronized input level for inputs.

Every input pin carries a two-bit sense code that selects one of four trigger conditions: level low, level high, rising edge or falling edge. The codes for the lower sixteen pins sit in one configuration register and those for the upper sixteen in the next register up. A matching condition sets a sticky per-pin status bit, which software clears by writing ones. The status bits are ANDed with a per-pin mask and ORed into interrupt lines. A build parameter chooses between one line for the whole bank and two lines, one for each half.

Top module: `gpio_irq_bank`

## Requirements
- R1: While reset is held and in the first cycle after it, every register reads zero. The direction register is therefore zero, so `pin_oe` is all zeros, and the mask is zero, so both `irq_lines` bits are 0.
- R2: After a write, the register at byte offset 0x04 (direction, 1 = output) appears on `pin_oe` and the register at offset 0x00 (data) appears on `pin_out`, both one cycle after the write edge.
- R3: A read of offset 0x00 returns, bit by bit, the stored data bit for output pins and the synchronized input for input pins. A change on `pin_in` first shows up in that read after the second rising clock edge that follows it.
- R4: Sense codes are 2 bits per pin. Pins 0 to 15 use the register at 0x08 and pins 16 to 31 use the register at 0x0C. Pin p's field sits at bit 2*(p mod 16). The code values are 0 = level low, 1 = level high, 2 = rising edge and 3 = falling edge.
- R5: For a level code, the status bit is set on every clock edge at which the synchronized input holds the active level. A clear written while the level persists therefore leaves the bit set.
- R6: For an edge code, only the selected transition sets the status bit. The bit becomes visible after the third rising edge that follows the pin change, and it stays set until software clears it. The opposite transition does not set it.
- R7: Writing to the status register at 0x14 clears each bit written as 1 and leaves each bit written as 0 unchanged. When a set and a clear of the same bit happen in the same cycle, the set wins.
- R8: An interrupt line is driven only by status bits whose mask bit (register 0x10) is 1. Status still latches while the pin is masked.
- R9: With `SPLIT_IRQ` = 1, `irq_lines[0]` ORs the masked status of pins 0 to 15 and `irq_lines[1]` ORs pins 16 to 31. With `SPLIT_IRQ` = 0, `irq_lines[0]` ORs all 32 pins and `irq_lines[1]` stays 0.
- R10: Only the offsets 0x00, 0x04, 0x08, 0x0C, 0x10 and 0x14 are decoded. A read of any other offset returns zero, and a write to any other offset changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, qualified by `bus_sel` |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pin_in | input | 32 | Levels sampled from the pins |
| pin_out | output | 32 | Levels driven on the pins |
| pin_oe | output | 32 | Output enable per pin |
| irq_lines | output | 2 | Combined interrupt requests |

## Verification
Register writes take effect at the write edge, so reads and `pin_oe`/`pin_out` are checked in the half-cycle that follows. A pin change needs two rising edges before it reaches the data read and three before it sets a status bit or an interrupt line. The bench changes pins on a falling edge and reads back at each following falling edge, so it confirms that the value is absent one edge early and present on time. Mask and clear writes act on the outputs at the next edge, and the bench samples them right after that edge.

// File: rtl/gpio_bank_pkg.sv
// Shared constants and types for the GPIO bank.
// Assumes a byte-addressed register window with word-aligned registers.
package gpio_bank_pkg;

    localparam int ADDR_W = 5;

    localparam logic [ADDR_W-1:0] OFS_DATA     = 5'h00;
    localparam logic [ADDR_W-1:0] OFS_DIR      = 5'h04;
    localparam logic [ADDR_W-1:0] OFS_SENSE_LO = 5'h08;
    localparam logic [ADDR_W-1:0] OFS_SENSE_HI = 5'h0C;
    localparam logic [ADDR_W-1:0] OFS_MASK     = 5'h10;
    localparam logic [ADDR_W-1:0] OFS_STAT     = 5'h14;

    typedef enum logic [1:0] {
        SENSE_LOW  = 2'd0,
        SENSE_HIGH = 2'd1,
        SENSE_RISE = 2'd2,
        SENSE_FALL = 2'd3
    } sense_e;

endpackage

// File: rtl/gpio_bank_regs.sv
// Register decode and storage for the GPIO bank.
// Holds data, direction, sense codes and mask. Produces the read mux and
// the write-one-to-clear strobe for status. Assumes a single-cycle
// access: a write is taken at the edge where bus_sel and bus_wr are high.
module gpio_bank_regs
    import gpio_bank_pkg::*;
#(
    parameter int NUM_PINS = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_sel,
    input  logic                  bus_wr,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [NUM_PINS-1:0]   bus_wdata,
    input  logic [NUM_PINS-1:0]   pin_sync,
    input  logic [NUM_PINS-1:0]   status_q,
    output logic [NUM_PINS-1:0]   bus_rdata,
    output logic [NUM_PINS-1:0]   data_q,
    output logic [NUM_PINS-1:0]   dir_q,
    output logic [2*NUM_PINS-1:0] sense_q,
    output logic [NUM_PINS-1:0]   mask_q,
    output logic [NUM_PINS-1:0]   clr_mask
);

    localparam int CFG_W = NUM_PINS;

    logic wr_en;
    logic wr_data, wr_dir, wr_sense_lo, wr_sense_hi, wr_mask, wr_stat;
    logic [NUM_PINS-1:0] pin_view;

    // Decode which register a write targets.
    always_comb begin
        wr_en       = bus_sel & bus_wr;
        wr_data     = wr_en & (bus_addr == OFS_DATA);
        wr_dir      = wr_en & (bus_addr == OFS_DIR);
        wr_sense_lo = wr_en & (bus_addr == OFS_SENSE_LO);
        wr_sense_hi = wr_en & (bus_addr == OFS_SENSE_HI);
        wr_mask     = wr_en & (bus_addr == OFS_MASK);
        wr_stat     = wr_en & (bus_addr == OFS_STAT);
    end

    // Data register: output levels.
    always_ff @(posedge clk) begin
        if (!rst_n)       data_q <= '0;
        else if (wr_data) data_q <= bus_wdata;
    end

    // Direction register: 1 = output.
    always_ff @(posedge clk) begin
        if (!rst_n)      dir_q <= '0;
        else if (wr_dir) dir_q <= bus_wdata;
    end

    // Sense codes, lower register then upper register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sense_q <= '0;
        end else begin
            if (wr_sense_lo) sense_q[CFG_W-1:0]       <= bus_wdata;
            if (wr_sense_hi) sense_q[2*CFG_W-1:CFG_W] <= bus_wdata;
        end
    end

    // Interrupt mask register.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= '0;
        else if (wr_mask) mask_q <= bus_wdata;
    end

    // Clear strobe for status, the written ones.
    assign clr_mask = wr_stat ? bus_wdata : '0;

    // Pin view: driven level for outputs, sampled level for inputs.
    assign pin_view = (data_q & dir_q) | (pin_sync & ~dir_q);

    // Read mux; unmapped offsets return zero.
    always_comb begin
        case (bus_addr)
            OFS_DATA:     bus_rdata = pin_view;
            OFS_DIR:      bus_rdata = dir_q;
            OFS_SENSE_LO: bus_rdata = sense_q[CFG_W-1:0];
            OFS_SENSE_HI: bus_rdata = sense_q[2*CFG_W-1:CFG_W];
            OFS_MASK:     bus_rdata = mask_q;
            OFS_STAT:     bus_rdata = status_q;
            default:      bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/gpio_bank_sync.sv
// Input synchronizer for the GPIO bank.
// A chain of SYNC_STAGES flops per pin, followed by one more flop that
// holds the previous synchronized value for edge detection.
// Assumes pin_in is asynchronous to clk.
module gpio_bank_sync #(
    parameter int NUM_PINS    = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic [NUM_PINS-1:0] sync_q,
    output logic [NUM_PINS-1:0] prev_q
);

    logic [NUM_PINS-1:0] chain_q [SYNC_STAGES];

    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            // First stage samples the raw pins.
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q[s] <= '0;
                else        chain_q[s] <= pin_in;
            end
        end else begin : g_next
            // Later stages settle metastability.
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q[s] <= '0;
                else        chain_q[s] <= chain_q[s-1];
            end
        end
    end

    assign sync_q = chain_q[SYNC_STAGES-1];

    // Previous synchronized value for edge compare.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= sync_q;
    end

endmodule

// File: rtl/gpio_bank_sense.sv
// Per-pin trigger detection and sticky status for the GPIO bank.
// Evaluates each pin's 2-bit sense code against the synchronized level
// and its previous value. Sets status bits, and clears them on a
// write-one-to-clear strobe; a set in the same cycle wins over a clear.
module gpio_bank_sense
    import gpio_bank_pkg::*;
#(
    parameter int NUM_PINS = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_PINS-1:0]   sync_q,
    input  logic [NUM_PINS-1:0]   prev_q,
    input  logic [2*NUM_PINS-1:0] sense_q,
    input  logic [NUM_PINS-1:0]   clr_mask,
    output logic [NUM_PINS-1:0]   status_q
);

    logic [NUM_PINS-1:0] hit;

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        sense_e code;
        assign code = sense_e'(sense_q[2*p +: 2]);

        // Match this pin against its trigger condition.
        always_comb begin
            case (code)
                SENSE_LOW:  hit[p] = ~sync_q[p];
                SENSE_HIGH: hit[p] =  sync_q[p];
                SENSE_RISE: hit[p] =  sync_q[p] & ~prev_q[p];
                SENSE_FALL: hit[p] = ~sync_q[p] &  prev_q[p];
                default:    hit[p] = 1'b0;
            endcase
        end
    end

    // Sticky status: clear written ones, then merge new hits.
    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= (status_q & ~clr_mask) | hit;
    end

endmodule

// File: rtl/gpio_bank_irq.sv
// Interrupt combining for the GPIO bank.
// Gates status by the mask, then ORs into one line for the whole bank
// or one line per half, chosen by SPLIT_IRQ. Purely combinational.
module gpio_bank_irq #(
    parameter int NUM_PINS  = 32,
    parameter bit SPLIT_IRQ = 1'b1
) (
    input  logic [NUM_PINS-1:0] status_q,
    input  logic [NUM_PINS-1:0] mask_q,
    output logic [1:0]          irq_lines
);

    localparam int HALF = NUM_PINS / 2;

    logic [NUM_PINS-1:0] pend;

    assign pend = status_q & mask_q;

    if (SPLIT_IRQ) begin : g_split
        // One request per half of the bank.
        assign irq_lines[0] = |pend[HALF-1:0];
        assign irq_lines[1] = |pend[NUM_PINS-1:HALF];
    end else begin : g_single
        // A single request for the whole bank.
        assign irq_lines[0] = |pend;
        assign irq_lines[1] = 1'b0;
    end

endmodule

// File: rtl/gpio_irq_bank.sv
// Top of the GPIO bank: register file, input synchronizer, trigger
// detection and interrupt combining. Assumes 32 pins split into two
// halves of 16 for the sense-code registers and the split interrupt mode.
module gpio_irq_bank
    import gpio_bank_pkg::*;
#(
    parameter int NUM_PINS    = 32,
    parameter int SYNC_STAGES = 2,
    parameter bit SPLIT_IRQ   = 1'b1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_sel,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [NUM_PINS-1:0] bus_wdata,
    output logic [NUM_PINS-1:0] bus_rdata,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic [NUM_PINS-1:0] pin_out,
    output logic [NUM_PINS-1:0] pin_oe,
    output logic [1:0]          irq_lines
);

    logic [NUM_PINS-1:0]   sync_q, prev_q;
    logic [NUM_PINS-1:0]   status_q, mask_q, clr_mask;
    logic [NUM_PINS-1:0]   data_q, dir_q;
    logic [2*NUM_PINS-1:0] sense_q;

    gpio_bank_regs #(.NUM_PINS(NUM_PINS)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .pin_sync  (sync_q),
        .status_q  (status_q),
        .bus_rdata (bus_rdata),
        .data_q    (data_q),
        .dir_q     (dir_q),
        .sense_q   (sense_q),
        .mask_q    (mask_q),
        .clr_mask  (clr_mask)
    );

    gpio_bank_sync #(.NUM_PINS(NUM_PINS), .SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_in (pin_in),
        .sync_q (sync_q),
        .prev_q (prev_q)
    );

    gpio_bank_sense #(.NUM_PINS(NUM_PINS)) u_sense (
        .clk      (clk),
        .rst_n    (rst_n),
        .sync_q   (sync_q),
        .prev_q   (prev_q),
        .sense_q  (sense_q),
        .clr_mask (clr_mask),
        .status_q (status_q)
    );

    gpio_bank_irq #(.NUM_PINS(NUM_PINS), .SPLIT_IRQ(SPLIT_IRQ)) u_irq (
        .status_q  (status_q),
        .mask_q    (mask_q),
        .irq_lines (irq_lines)
    );

    assign pin_out = data_q;
    assign pin_oe  = dir_q;

endmodule

// File: rtl/gpio_irq_bank_chk.sv
// Property checker for the GPIO bank, bound to every gpio_irq_bank
// instance. Observes the bus, the pin enables, the interrupt lines and
// the internal status vector.
module gpio_irq_bank_chk
    import gpio_bank_pkg::*;
#(
    parameter int NUM_PINS = 32
) (
    input logic                clk,
    input logic                rst_n,
    input logic                bus_sel,
    input logic                bus_wr,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic [NUM_PINS-1:0] bus_wdata,
    input logic [NUM_PINS-1:0] pin_oe,
    input logic [1:0]          irq_lines,
    input logic [NUM_PINS-1:0] status_q
);

    logic wr_any, wr_dir, wr_mask, wr_stat, wr_unmapped;

    assign wr_any      = bus_sel & bus_wr;
    assign wr_dir      = wr_any & (bus_addr == OFS_DIR);
    assign wr_mask     = wr_any & (bus_addr == OFS_MASK);
    assign wr_stat     = wr_any & (bus_addr == OFS_STAT);
    assign wr_unmapped = wr_any & !(bus_addr inside {OFS_DATA, OFS_DIR, OFS_SENSE_LO,
                                                     OFS_SENSE_HI, OFS_MASK, OFS_STAT});

    // R1: first cycle out of reset shows no enables and no requests.
    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pin_oe == '0 && irq_lines == 2'b00));

    // R2: a direction write shows on the enables one cycle later.
    assert_dir_to_oe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_dir |=> (pin_oe == $past(bus_wdata)));

    // R7: a status bit only drops after a status write.
    assert_clear_only_by_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (|($past(status_q) & ~status_q)) |-> $past(wr_stat));

    // R8: masking everything silences the interrupt lines.
    assert_mask_zero_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_mask && bus_wdata == '0) |=> (irq_lines == 2'b00));

    // R10: writes to unmapped offsets leave the direction alone.
    assert_unmapped_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_unmapped |=> $stable(pin_oe));

endmodule

bind gpio_irq_bank gpio_irq_bank_chk #(.NUM_PINS(NUM_PINS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .pin_oe    (pin_oe),
    .irq_lines (irq_lines),
    .status_q  (status_q)
);

// File: tb/gpio_irq_bank_tb.sv
module gpio_irq_bank_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = 5'h00;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata, rdata_single;
    logic [31:0] pin_in = '1;
    logic [31:0] pin_out, pin_oe, pout_single, poe_single;
    logic [1:0]  irq_lines, irq_single;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_irq_bank #(.SPLIT_IRQ(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq_lines(irq_lines));

    gpio_irq_bank #(.SPLIT_IRQ(1'b0)) u_dut_single (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata_single),
        .pin_in(pin_in), .pin_out(pout_single), .pin_oe(poe_single), .irq_lines(irq_single));

    typedef struct packed {
        logic [4:0]  waddr;
        logic [31:0] wdata;
        logic [4:0]  raddr;
        logic [31:0] expect_v;
    } vec_t;

    // Write then read back; tags R2, R4, R10 for the rows below.
    localparam vec_t VECS [8] = '{
        '{5'h04, 32'hFFFF_FFFF, 5'h04, 32'hFFFF_FFFF},  // R2 direction
        '{5'h00, 32'hDEAD_BEEF, 5'h00, 32'hDEAD_BEEF},  // R2 data, all outputs
        '{5'h08, 32'h1234_5678, 5'h08, 32'h1234_5678},  // R4 lower sense
        '{5'h0C, 32'h9ABC_DEF0, 5'h0C, 32'h9ABC_DEF0},  // R4 upper sense
        '{5'h10, 32'h0F0F_00FF, 5'h10, 32'h0F0F_00FF},  // R8 mask storage
        '{5'h18, 32'hFFFF_FFFF, 5'h18, 32'h0000_0000},  // R10 unmapped read
        '{5'h01, 32'h0000_0000, 5'h04, 32'hFFFF_FFFF},  // R10 misaligned write
        '{5'h1C, 32'h0000_0000, 5'h00, 32'hDEAD_BEEF}   // R10 unmapped write
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp_v);
        checks++;
        if (act !== exp_v) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp_v);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic peek(input logic [4:0] a, output logic [31:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] v;

        // R1: reset state while reset is held.
        idle(3);
        peek(5'h00, v); check("R1 data", v, 32'h0);
        peek(5'h04, v); check("R1 dir", v, 32'h0);
        peek(5'h08, v); check("R1 sense lo", v, 32'h0);
        peek(5'h0C, v); check("R1 sense hi", v, 32'h0);
        peek(5'h10, v); check("R1 mask", v, 32'h0);
        peek(5'h14, v); check("R1 status", v, 32'h0);
        check("R1 pin_oe", pin_oe, 32'h0);
        check("R1 irq", {30'd0, irq_lines}, 32'h0);
        rst_n = 1'b1;
        idle(4);

        // Table walk: register write and readback.
        for (int i = 0; i < 8; i++) begin
            wr(VECS[i].waddr, VECS[i].wdata);
            peek(VECS[i].raddr, v);
            check($sformatf("R10 table row %0d", i), v, VECS[i].expect_v);
        end
        check("R2 pin_oe", pin_oe, 32'hFFFF_FFFF);
        check("R2 pin_out", pin_out, 32'hDEAD_BEEF);

        // R3: mixed directions and input latency.
        wr(5'h08, 32'h0); wr(5'h0C, 32'h0); wr(5'h10, 32'h0);
        wr(5'h04, 32'h0000_FFFF);
        wr(5'h00, 32'hA5A5_5A5A);
        pin_in = 32'h1234_FFFF;
        idle(3);
        peek(5'h00, v); check("R3 mixed read", v, 32'h1234_5A5A);
        pin_in = 32'h8765_FFFF;
        peek(5'h00, v); check("R3 before first edge", v, 32'h1234_5A5A);
        @(negedge clk);
        peek(5'h00, v); check("R3 after one edge", v, 32'h1234_5A5A);
        @(negedge clk);
        peek(5'h00, v); check("R3 after two edges", v, 32'h8765_5A5A);

        // Edge sensing: pin 3 rising, pin 20 falling (R4 field positions).
        wr(5'h04, 32'h0);
        pin_in = '1;
        wr(5'h08, 32'h0000_0080);
        wr(5'h0C, 32'h0000_0300);
        pin_in[3] = 1'b0;
        idle(4);
        wr(5'h14, 32'hFFFF_FFFF);
        peek(5'h14, v); check("R7 clear all", v, 32'h0);
        pin_in[3] = 1'b1;
        peek(5'h14, v); check("R6 rise no edge yet", v, 32'h0);
        @(negedge clk);
        peek(5'h14, v); check("R6 rise edge 1", v, 32'h0);
        @(negedge clk);
        peek(5'h14, v); check("R6 rise edge 2", v, 32'h0);
        @(negedge clk);
        peek(5'h14, v); check("R6 rise edge 3", v, 32'h0000_0008);
        idle(4);
        peek(5'h14, v); check("R6 sticky", v, 32'h0000_0008);
        wr(5'h14, 32'h0);
        peek(5'h14, v); check("R7 write zero", v, 32'h0000_0008);
        wr(5'h14, 32'h0000_0008);
        peek(5'h14, v); check("R7 write one", v, 32'h0);
        pin_in[3] = 1'b0;
        idle(4);
        peek(5'h14, v); check("R6 opposite edge", v, 32'h0);
        pin_in[20] = 1'b0;
        idle(4);
        peek(5'h14, v); check("R6 R4 falling pin 20", v, 32'h0010_0000);
        wr(5'h14, 32'h0010_0000);

        // R5: level sensing, pin 5 high level, pin 7 low level.
        wr(5'h08, 32'h0000_0480);
        idle(1);
        peek(5'h14, v); check("R5 level high", v, 32'h0000_0020);
        wr(5'h14, 32'h0000_0020);
        peek(5'h14, v); check("R5 clear while active", v, 32'h0000_0020);
        pin_in[5] = 1'b0;
        idle(4);
        wr(5'h14, 32'h0000_0020);
        peek(5'h14, v); check("R5 clear after release", v, 32'h0);
        pin_in[7] = 1'b0;
        idle(4);
        peek(5'h14, v); check("R5 level low", v, 32'h0000_0080);

        // R8 and R9: masking and line split.
        check("R8 masked quiet", {30'd0, irq_lines}, 32'h0);
        wr(5'h10, 32'h0000_0080);
        check("R9 split low half", {30'd0, irq_lines}, 32'h1);
        check("R9 single low pin", {30'd0, irq_single}, 32'h1);
        pin_in[20] = 1'b1;
        idle(4);
        pin_in[20] = 1'b0;
        idle(4);
        peek(5'h14, v); check("R8 latched while masked", v, 32'h0010_0080);
        wr(5'h10, 32'h0010_0080);
        check("R9 split both", {30'd0, irq_lines}, 32'h3);
        wr(5'h10, 32'h0010_0000);
        check("R9 split high half", {30'd0, irq_lines}, 32'h2);
        check("R9 single high pin", {30'd0, irq_single}, 32'h1);
        wr(5'h10, 32'h0);
        check("R8 mask cleared", {30'd0, irq_lines}, 32'h0);
        check("R8 single mask cleared", {30'd0, irq_single}, 32'h0);

        finish_run();
    end

endmodule